// File: doc/BRIEF.md
# Momentum-Band Pile-Up Veto

This block makes the final keep-or-drop call on one muon candidate per clock. Each candidate arrives as two signed fixed-point words from an upstream network: a signed inverse transverse momentum (charge over pT) and a pile-up classifier score. In the score, zero stands for background and one for a genuine muon. The block sorts the candidate into one of three momentum bands without dividing. It applies the score cut that belongs to that band and reports an accept flag together with the charge sign.

The band test works on the magnitude of the inverse momentum. A large magnitude means a soft muon. Soft candidates are kept without looking at the score. Intermediate candidates must beat a loose score cut, and hard candidates must beat a tight one. The result is registered twice, so it appears a fixed two clocks after the candidate is presented. A fresh candidate may be presented on every clock.

Top module: `muon_pu_veto`

## Requirements
- R1: Both input words are 18-bit two's complement with 10 fraction bits (code 1024 means 1.0). The band edges and score cuts are the nearest codes to their real values: 1/8 GeV is 128, 1/14 GeV is 73, the loose cut 0.7415 is 759 and the tight cut 0.9136 is 936.
- R2: `out_valid` is `in_valid` delayed by exactly two rising clock edges, and a new candidate can be taken on every clock.
- R3: A valid candidate whose inverse-momentum magnitude is 128 or more (pT of 8 GeV or below) is accepted whatever its score.
- R4: A valid candidate whose magnitude is above 73 and below 128 is accepted only when its score code is greater than 759.
- R5: A valid candidate whose magnitude is 73 or less, including a zero inverse momentum, is accepted only when its score code is greater than 936.
- R6: The score cuts are strict and signed. A score equal to the cut is rejected, and so is any negative score in R4 or R5.
- R7: `out_charge_neg` is bit 17 (the sign bit) of the inverse-momentum word, delayed by two edges alongside `out_valid`. A zero word reports positive charge.
- R8: While `out_valid` is low, `out_accept` and `out_charge_neg` are low. During reset all three outputs are low.
- R9: The most negative inverse-momentum code (-131072) is handled without wrap-around: its magnitude falls in the R3 band and it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A candidate is present this cycle |
| in_q_over_pt | input | 18 | Signed charge over pT, 10 fraction bits |
| in_score | input | 18 | Signed pile-up classifier score, 10 fraction bits |
| out_valid | output | 1 | Decision present, two edges after its candidate |
| out_accept | output | 1 | Candidate kept |
| out_charge_neg | output | 1 | Candidate carries negative charge |

## Verification
The block holds only a two-deep pipeline, so any wrong internal state shows at the ports within two clocks. A band sorted wrongly shows as a decision that ignores the score, or one that applies the wrong cut. This only becomes visible for scores that lie between the two cuts or below the loose cut, so the stimulus concentrates scores around 759 and 936 and magnitudes around 73 and 128. A slip in the valid or sign pipeline shows as a decision one cycle off or a flipped charge. Back-to-back candidates with bubbles between them expose such a slip on the very next output.

// File: rtl/mpv_pkg.sv
package mpv_pkg;

  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_HIGH = 2'd2
  } pt_band_e;

  // Inverse of a momentum edge in GeV, as a fixed-point code rounded to nearest.
  function automatic int unsigned inv_pt_code(input int unsigned pt_gev,
                                              input int unsigned frac_w);
    return ((32'd1 << frac_w) + pt_gev / 2) / pt_gev;
  endfunction

  // A score cut given in units of 1e-4, as a fixed-point code rounded to nearest.
  function automatic int unsigned score_code(input int unsigned cut_e4,
                                             input int unsigned frac_w);
    return (cut_e4 * (32'd1 << frac_w) + 5000) / 10000;
  endfunction

  // Final call from the band and the two score comparisons.
  function automatic logic band_decision(input pt_band_e band,
                                         input logic pass_loose,
                                         input logic pass_tight);
    logic keep;
    case (band)
      BAND_LOW:  keep = 1'b1;
      BAND_MID:  keep = pass_loose;
      BAND_HIGH: keep = pass_tight;
      default:   keep = 1'b0;
    endcase
    return keep;
  endfunction

endpackage

// File: rtl/mpv_magnitude.sv
module mpv_magnitude #(
  parameter int unsigned W = 18
) (
  input  logic signed [W-1:0] q_word,
  output logic        [W-1:0] mag,
  output logic                neg
);
  logic [W-1:0] raw;

  always_comb begin
    raw = q_word;
    neg = raw[W-1];
    // Unsigned result keeps the most negative code as its true magnitude.
    mag = neg ? (~raw + {{(W-1){1'b0}}, 1'b1}) : raw;
  end
endmodule

// File: rtl/mpv_band_classifier.sv
module mpv_band_classifier
  import mpv_pkg::*;
#(
  parameter int unsigned W        = 18,
  parameter int unsigned LOW_EDGE = 128,
  parameter int unsigned MID_EDGE = 73
) (
  input  logic [W-1:0] mag,
  output pt_band_e     band
);
  localparam logic [W-1:0] LOW_EDGE_C = W'(LOW_EDGE);
  localparam logic [W-1:0] MID_EDGE_C = W'(MID_EDGE);

  always_comb begin
    if (mag >= LOW_EDGE_C)      band = BAND_LOW;
    else if (mag > MID_EDGE_C)  band = BAND_MID;
    else                        band = BAND_HIGH;
  end
endmodule

// File: rtl/mpv_score_gate.sv
module mpv_score_gate #(
  parameter int unsigned W     = 18,
  parameter int unsigned LOOSE = 759,
  parameter int unsigned TIGHT = 936
) (
  input  logic signed [W-1:0] score,
  output logic                pass_loose,
  output logic                pass_tight
);
  localparam logic signed [W-1:0] LOOSE_C = W'(LOOSE);
  localparam logic signed [W-1:0] TIGHT_C = W'(TIGHT);

  always_comb begin
    pass_loose = score > LOOSE_C;
    pass_tight = score > TIGHT_C;
  end
endmodule

// File: rtl/muon_pu_veto.sv
module muon_pu_veto
  import mpv_pkg::*;
#(
  parameter int unsigned DATA_W     = 18,
  parameter int unsigned FRAC_W     = 10,
  parameter int unsigned LOW_PT_GEV = 8,
  parameter int unsigned MID_PT_GEV = 14,
  parameter int unsigned LOOSE_E4   = 7415,
  parameter int unsigned TIGHT_E4   = 9136
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_q_over_pt,
  input  logic signed [DATA_W-1:0] in_score,
  output logic                     out_valid,
  output logic                     out_accept,
  output logic                     out_charge_neg
);
  localparam int unsigned LOW_EDGE  = inv_pt_code(LOW_PT_GEV, FRAC_W);
  localparam int unsigned MID_EDGE  = inv_pt_code(MID_PT_GEV, FRAC_W);
  localparam int unsigned LOOSE_CUT = score_code(LOOSE_E4, FRAC_W);
  localparam int unsigned TIGHT_CUT = score_code(TIGHT_E4, FRAC_W);

  // Combinational front end
  logic [DATA_W-1:0] q_mag;
  logic              q_neg;
  pt_band_e          band_c;
  logic              loose_c, tight_c;

  mpv_magnitude #(.W(DATA_W)) u_mag (
    .q_word (in_q_over_pt),
    .mag    (q_mag),
    .neg    (q_neg)
  );

  mpv_band_classifier #(.W(DATA_W), .LOW_EDGE(LOW_EDGE), .MID_EDGE(MID_EDGE)) u_band (
    .mag  (q_mag),
    .band (band_c)
  );

  mpv_score_gate #(.W(DATA_W), .LOOSE(LOOSE_CUT), .TIGHT(TIGHT_CUT)) u_gate (
    .score      (in_score),
    .pass_loose (loose_c),
    .pass_tight (tight_c)
  );

  // Stage 1: band and comparisons, named for the checker
  logic     s1_valid;
  pt_band_e s1_band;
  logic     s1_pass_loose, s1_pass_tight, s1_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid      <= 1'b0;
      s1_band       <= BAND_LOW;
      s1_pass_loose <= 1'b0;
      s1_pass_tight <= 1'b0;
      s1_neg        <= 1'b0;
    end else begin
      s1_valid      <= in_valid;
      s1_band       <= band_c;
      s1_pass_loose <= loose_c;
      s1_pass_tight <= tight_c;
      s1_neg        <= in_valid & q_neg;
    end
  end

  // Stage 2: decision
  logic keep_c;
  always_comb keep_c = band_decision(s1_band, s1_pass_loose, s1_pass_tight);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_accept     <= 1'b0;
      out_charge_neg <= 1'b0;
    end else begin
      out_valid      <= s1_valid;
      out_accept     <= s1_valid & keep_c;
      out_charge_neg <= s1_valid & s1_neg;
    end
  end
endmodule

// File: rtl/mpv_checker.sv
module mpv_checker
  import mpv_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     in_valid,
  input logic     in_q_msb,
  input logic     s1_valid,
  input pt_band_e s1_band,
  input logic     s1_pass_loose,
  input logic     s1_pass_tight,
  input logic     out_valid,
  input logic     out_accept,
  input logic     out_charge_neg
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_low_band_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_band == BAND_LOW) |=> out_accept);

  assert_mid_band_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_band == BAND_MID && !s1_pass_loose) |=> !out_accept);

  assert_high_band_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_band == BAND_HIGH) |=> (out_accept == $past(s1_pass_tight)));

  assert_charge_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && out_valid) |-> (out_charge_neg == $past(in_q_msb, 2)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_accept && !out_charge_neg));
endmodule

bind muon_pu_veto mpv_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_q_msb       (in_q_over_pt[DATA_W-1]),
  .s1_valid       (s1_valid),
  .s1_band        (s1_band),
  .s1_pass_loose  (s1_pass_loose),
  .s1_pass_tight  (s1_pass_tight),
  .out_valid      (out_valid),
  .out_accept     (out_accept),
  .out_charge_neg (out_charge_neg)
);

// File: tb/muon_pu_veto_test.sv
module muon_pu_veto_test;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [W-1:0] in_q_over_pt;
  logic signed [W-1:0] in_score;
  logic out_valid, out_accept, out_charge_neg;

  muon_pu_veto uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_q_over_pt   (in_q_over_pt),
    .in_score       (in_score),
    .out_valid      (out_valid),
    .out_accept     (out_accept),
    .out_charge_neg (out_charge_neg)
  );

  always #4 clk = ~clk;

  typedef struct {
    bit    v;
    bit    acc;
    bit    neg;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int loose_cut, tight_cut;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Behavioural reference from the requirements, using real arithmetic.
  function automatic exp_t model(input bit v, input int q, input int d);
    exp_t e;
    real  pt;
    int   band;
    int   aq;
    e.v   = v;
    e.neg = v && (q < 0);
    aq    = (q < 0) ? -q : q;
    if (q == 0) band = 2;
    else begin
      pt = 1024.0 / real'(aq);
      if (pt <= 8.0)       band = 0;
      else if (pt <= 14.0) band = 1;
      else                 band = 2;
    end
    if (!v) begin
      e.acc = 0;
      e.tag = "R8";
    end else if (band == 0) begin
      e.acc = 1;
      e.tag = (q == -131072) ? "R3 R9" : "R3 R1";
    end else if (band == 1) begin
      e.acc = d > loose_cut;
      e.tag = (d <= 0 || d == loose_cut) ? "R4 R6" : "R4 R1";
    end else begin
      e.acc = d > tight_cut;
      e.tag = (d <= 0 || d == tight_cut) ? "R5 R6" : "R5 R1";
    end
    return e;
  endfunction

  task automatic step(input bit v, input int q, input int d);
    exp_t e;
    @(negedge clk);
    if (exp_q.size() >= 2) begin
      e = exp_q.pop_front();
      check(out_valid == e.v, "R2 valid", int'(out_valid), int'(e.v));
      check(out_accept == e.acc, {e.tag, " accept"}, int'(out_accept), int'(e.acc));
      check(out_charge_neg == e.neg, e.v ? "R7 charge" : "R8 charge",
            int'(out_charge_neg), int'(e.neg));
    end
    in_valid     = v;
    in_q_over_pt = W'(q);
    in_score     = W'(d);
    exp_q.push_back(model(v, q, d));
  endtask

  int cq[16] = '{128, -128, 129, 127, 127, -74, 73, 73, 0, 0, -131072, -50, 1, 200, -73, 74};
  int cd[16] = '{0, -500, -131072, 760, 759, 760, 936, 937, 937, 936, -131072, -1, 131071, -2, 1000, 759};

  initial begin
    exp_t blank;
    loose_cut = $rtoi(0.7415 * 1024.0 + 0.5);
    tight_cut = $rtoi(0.9136 * 1024.0 + 0.5);
    rst_n = 1'b0; in_valid = 1'b0; in_q_over_pt = '0; in_score = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_accept == 0 && out_charge_neg == 0, "R8 reset",
          int'({out_valid, out_accept, out_charge_neg}), 0);
    rst_n = 1'b1;
    blank.v = 0; blank.acc = 0; blank.neg = 0; blank.tag = "R8";
    exp_q.push_back(blank);
    exp_q.push_back(blank);
    for (int i = 0; i < 16; i++) step(1'b1, cq[i], cd[i]);
    for (int i = 0; i < 16; i++) step(i[0], cq[15-i], cd[i]);
    for (int i = 0; i < 800; i++) begin
      int q, d, r;
      bit v;
      v = ($urandom % 4) != 0;
      r = $urandom % 4;
      case (r)
        0: q = int'($urandom % 201) - 100;
        1: q = ($urandom % 2 ? -1 : 1) * (60 + int'($urandom % 81));
        2: q = int'($urandom % 262144) - 131072;
        default: q = 0;
      endcase
      if ($urandom % 3 == 0) d = int'($urandom % 262144) - 131072;
      else d = 700 + int'($urandom % 300);
      step(v, q, d);
    end
    repeat (3) step(1'b0, 0, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule